// File: doc/BRIEF.md
# SPI Word-Packing Data FIFO

This block sits between a 32-bit host register port and a byte-wide serial shift engine. On the transmit side the host writes whole words. Each word is split into bytes and queued in a 32-byte transmit FIFO. On the receive side, bytes from the shift engine go into a 32-byte receive FIFO, and the host reads them back as words. Each direction has two settings. The first reverses the byte order within a word (lane order). The second reverses the bit order within each byte, so the shift engine, which always moves bit 7 first, can send and receive least-significant-bit-first traffic.

A transfer whose length is not a multiple of four uses a final word in which only the low lanes hold data. A byte-count field on each write gives the number of valid lanes. A host read takes up to four bytes. When fewer are waiting, the read returns those bytes in their lanes and zeros in the other lanes. A dummy mode feeds the shift engine a constant byte so that a receive-only transfer still clocks data in. A flush input empties both FIFOs and clears the sticky error flags.

Top module: `spi_word_fifo`

## Requirements
- R1: After reset both fill levels read 0, both sticky flags read 0, tx_valid is low while tx_dummy is low, and rx_ready is high.
- R2: An accepted write queues k bytes, where k equals wr_nbytes for codes 1 to 3 and equals 4 for every other code. With tx_swap=0 the bytes are queued in order lane 0, lane 1, and so on, where lane i is wr_data[8i+7:8i]. Lanes at index k or above are discarded.
- R3: With tx_swap=1 an accepted write queues its k valid lanes in reverse order, from lane k-1 down to lane 0.
- R4: With tx_lsb_first=0 a byte leaves on tx_byte unchanged, and with tx_lsb_first=1 it leaves bit-reversed (bit i becomes bit 7-i). The same rule applies to rx_byte, through rx_lsb_first, before the byte is stored. A value of 0 (MSB-first) is the default.
- R5: rd_data shows the next k = min(4, rx_level) received bytes. With rx_swap=0 the j-th oldest byte sits in lane j. With rx_swap=1 it sits in lane k-1-j. Lanes at index k or above read zero. A read with rd_en removes exactly those k bytes.
- R6: Each FIFO holds 32 bytes. rx_ready is low exactly when rx_level is 32, and a byte offered while rx_ready is low is not stored.
- R7: A write whose k exceeds the free transmit space is ignored entirely and sets tx_overflow. tx_overflow stays set until flush or reset.
- R8: A read while rx_level is 0 is ignored. rd_data reads zero at that time. The read sets rx_underflow, which stays set until flush or reset.
- R9: While tx_dummy is 1, tx_valid is 1 and tx_byte equals DUMMY_BYTE (default 8'hFF), and the transmit FIFO is not consumed.
- R10: A flush empties both FIFOs and clears both flags on the next clock edge. It takes priority over writes, reads and received bytes in the same cycle.
- R11: tx_level and rx_level give the stored byte counts. They change on the clock edge that follows the event that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Soft reset: empty both FIFOs, clear flags |
| tx_swap | input | 1 | Reverse lane order of written words |
| tx_lsb_first | input | 1 | Bit-reverse outgoing bytes |
| rx_swap | input | 1 | Reverse lane order of read words |
| rx_lsb_first | input | 1 | Bit-reverse incoming bytes |
| tx_dummy | input | 1 | Present the dummy byte instead of FIFO data |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host write word |
| wr_nbytes | input | 3 | Valid lanes in the write (1-3, other codes mean 4) |
| rd_en | input | 1 | Host word read strobe |
| rd_data | output | 32 | Word available to the host read |
| tx_valid | output | 1 | Byte available to the shift engine |
| tx_ready | input | 1 | Shift engine accepts tx_byte |
| tx_byte | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Shift engine offers rx_byte |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_byte | input | 8 | Incoming byte |
| tx_level | output | 6 | Bytes held in the transmit FIFO |
| rx_level | output | 6 | Bytes held in the receive FIFO |
| tx_overflow | output | 1 | Sticky: a write was refused |
| rx_underflow | output | 1 | Sticky: a read found nothing |

## Verification
Transmit words are written with full and partial byte counts, with lane reversal on and off, and with bit reversal on and off. A lane-order error, a mix-up between wrong and right valid lanes, or a missing bit reversal each shows up as a different wrong byte at the shifter. Receive traffic is read back as full words and as a three-byte and two-byte tail in both lane orders, which tells zero-filling apart from lane placement. Fill-to-the-brim patterns cover the refused write. One refused write has exactly one byte too few of free space, and the drained stream must show that none of its bytes were queued. They also cover the refused byte at a full receive FIFO, an empty read, dummy mode with data waiting, and a flush that coincides with a write.

// File: rtl/spi_wf_pkg.sv
package spi_wf_pkg;

    typedef logic [7:0] byte_t;

    // Mirror the bits of a byte: bit i moves to bit 7-i.
    function automatic byte_t bit_rev(input byte_t b);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[i] = b[7-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_wf_ring.sv
// Byte ring with a multi-lane write side and a multi-lane read side.
// DEPTH must be a power of two. The caller keeps pushes within the free
// space and pops within the level.
module spi_wf_ring #(
    parameter  int DEPTH     = 32,
    parameter  int IN_LANES  = 1,
    parameter  int OUT_LANES = 1,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int IW        = $clog2(IN_LANES + 1),
    localparam int OW        = $clog2(OUT_LANES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [IW-1:0]                 push_cnt,
    input  logic [IN_LANES-1:0][7:0]      push_data,
    input  logic [OW-1:0]                 pop_cnt,
    output logic [OUT_LANES-1:0][7:0]     peek,
    output logic [CW-1:0]                 level
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < IN_LANES; i++) begin
            if (i < int'(push_cnt)) begin
                st_d.mem[st_q.wp + AW'(i)] = push_data[i];
            end
        end
        st_d.wp  = st_q.wp + AW'(push_cnt);
        st_d.rp  = st_q.rp + AW'(pop_cnt);
        st_d.cnt = st_q.cnt + CW'(push_cnt) - CW'(pop_cnt);
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int j = 0; j < OUT_LANES; j++) begin
            peek[j] = st_q.mem[st_q.rp + AW'(j)];
        end
    end

    assign level = st_q.cnt;

endmodule

// File: rtl/spi_wf_tx_order.sv
// Turns a host word and its byte-count code into an ordered byte list.
module spi_wf_tx_order #(
    parameter  int LANES = 4,
    localparam int NB_W  = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0][7:0] word,
    input  logic [NB_W-1:0]       nbytes,
    input  logic                  swap,
    output logic [LANES-1:0][7:0] ordered,
    output logic [NB_W-1:0]       count
);

    int k;
    int idx;

    always_comb begin
        if (int'(nbytes) >= 1 && int'(nbytes) < LANES) begin
            k = int'(nbytes);
        end else begin
            k = LANES;
        end
        count = NB_W'(k);
        for (int i = 0; i < LANES; i++) begin
            ordered[i] = '0;
            idx        = swap ? (k - 1 - i) : i;
            if (i < k) begin
                ordered[i] = word[idx];
            end
        end
    end

endmodule

// File: rtl/spi_wf_rx_order.sv
// Places the oldest received bytes into word lanes, zero-filling the rest.
module spi_wf_rx_order #(
    parameter  int LANES = 4,
    parameter  int CW    = 6,
    localparam int NB_W  = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0][7:0] peek,
    input  logic [CW-1:0]         level,
    input  logic                  swap,
    output logic [LANES-1:0][7:0] word,
    output logic [NB_W-1:0]       take
);

    int k;
    int idx;

    always_comb begin
        k    = (int'(level) < LANES) ? int'(level) : LANES;
        take = NB_W'(k);
        for (int i = 0; i < LANES; i++) begin
            word[i] = '0;
            idx     = swap ? (k - 1 - i) : i;
            if (i < k) begin
                word[i] = peek[idx];
            end
        end
    end

endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter  int           DEPTH      = 32,
    parameter  int           LANES      = 4,
    parameter  logic [7:0]   DUMMY_BYTE = 8'hFF,
    localparam int           WORD_W     = 8 * LANES,
    localparam int           NB_W       = $clog2(LANES + 1),
    localparam int           CW         = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tx_swap,
    input  logic              tx_lsb_first,
    input  logic              rx_swap,
    input  logic              rx_lsb_first,
    input  logic              tx_dummy,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NB_W-1:0]   wr_nbytes,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_byte,
    output logic [CW-1:0]     tx_level,
    output logic [CW-1:0]     rx_level,
    output logic              tx_overflow,
    output logic              rx_underflow
);
    import spi_wf_pkg::*;

    typedef struct packed {
        logic ovf;
        logic udf;
    } flags_t;

    flags_t flg_d, flg_q;

    // transmit side
    logic [LANES-1:0][7:0] tx_ordered;
    logic [NB_W-1:0]       tx_cnt;
    logic                  wr_ok;
    logic [NB_W-1:0]       tx_push_cnt;
    logic [0:0][7:0]       tx_peek;
    logic                  tx_pop;

    // receive side
    logic [LANES-1:0][7:0] rx_peek;
    logic [LANES-1:0][7:0] rx_word;
    logic [NB_W-1:0]       rx_take;
    logic                  rd_ok;
    logic [NB_W-1:0]       rx_pop_cnt;
    logic                  rx_push;
    logic [0:0][7:0]       rx_in;

    spi_wf_tx_order #(.LANES(LANES)) u_tx_order (
        .word    (wr_data),
        .nbytes  (wr_nbytes),
        .swap    (tx_swap),
        .ordered (tx_ordered),
        .count   (tx_cnt)
    );

    always_comb begin
        wr_ok       = wr_en && (int'(tx_cnt) <= DEPTH - int'(tx_level));
        tx_push_cnt = wr_ok ? tx_cnt : '0;
        tx_pop      = tx_ready && !tx_dummy && (tx_level != '0);
        tx_valid    = tx_dummy || (tx_level != '0);
        if (tx_dummy) begin
            tx_byte = DUMMY_BYTE;
        end else if (tx_lsb_first) begin
            tx_byte = bit_rev(tx_peek[0]);
        end else begin
            tx_byte = tx_peek[0];
        end
    end

    spi_wf_ring #(.DEPTH(DEPTH), .IN_LANES(LANES), .OUT_LANES(1)) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_cnt  (tx_push_cnt),
        .push_data (tx_ordered),
        .pop_cnt   (tx_pop),
        .peek      (tx_peek),
        .level     (tx_level)
    );

    always_comb begin
        rx_ready   = (int'(rx_level) != DEPTH);
        rx_push    = rx_valid && rx_ready;
        rx_in[0]   = rx_lsb_first ? bit_rev(rx_byte) : rx_byte;
        rd_ok      = rd_en && (rx_level != '0);
        rx_pop_cnt = rd_ok ? rx_take : '0;
        rd_data    = rx_word;
    end

    spi_wf_ring #(.DEPTH(DEPTH), .IN_LANES(1), .OUT_LANES(LANES)) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_cnt  (rx_push),
        .push_data (rx_in),
        .pop_cnt   (rx_pop_cnt),
        .peek      (rx_peek),
        .level     (rx_level)
    );

    spi_wf_rx_order #(.LANES(LANES), .CW(CW)) u_rx_order (
        .peek  (rx_peek),
        .level (rx_level),
        .swap  (rx_swap),
        .word  (rx_word),
        .take  (rx_take)
    );

    // sticky error flags
    always_comb begin
        flg_d = flg_q;
        if (wr_en && !wr_ok) begin
            flg_d.ovf = 1'b1;
        end
        if (rd_en && !rd_ok) begin
            flg_d.udf = 1'b1;
        end
        if (flush) begin
            flg_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign tx_overflow  = flg_q.ovf;
    assign rx_underflow = flg_q.udf;

endmodule

// File: rtl/spi_wf_checker.sv
module spi_wf_checker #(
    parameter  int         DEPTH      = 32,
    parameter  int         LANES      = 4,
    parameter  logic [7:0] DUMMY_BYTE = 8'hFF,
    localparam int         WORD_W     = 8 * LANES,
    localparam int         CW         = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              tx_dummy,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_data,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              rx_ready,
    input logic [CW-1:0]     tx_level,
    input logic [CW-1:0]     rx_level,
    input logic              tx_overflow,
    input logic              rx_underflow
);

    a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

    a_r6_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_level) == DEPTH) |-> !rx_ready);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && int'(tx_level) == DEPTH) |=> tx_overflow);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow && !flush) |=> tx_overflow);

    a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !flush && rx_level == '0) |=> rx_underflow);

    a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> (rd_data == '0));

    a_r9_dummy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dummy && !wr_en && !flush) |=> (tx_level == $past(tx_level)));

    a_r9_dummy_out: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dummy |-> (tx_valid && tx_byte == DUMMY_BYTE));

    a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0 && rx_level == '0 && !tx_overflow && !rx_underflow));

endmodule

bind spi_word_fifo spi_wf_checker #(
    .DEPTH(DEPTH), .LANES(LANES), .DUMMY_BYTE(DUMMY_BYTE)
) u_spi_wf_checker (.*);

// File: tb/test_spi_word_fifo.sv
`timescale 1ns/1ps
module test_spi_word_fifo;
    localparam int         DEPTH = 32;
    localparam int         LANES = 4;
    localparam logic [7:0] DUMMY = 8'hFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        tx_swap = 1'b0, tx_lsb_first = 1'b0;
    logic        rx_swap = 1'b0, rx_lsb_first = 1'b0;
    logic        tx_dummy = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  wr_nbytes = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_byte = '0;
    logic [5:0]  tx_level, rx_level;
    logic        tx_overflow, rx_underflow;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #2 clk = ~clk;

    spi_word_fifo i_spi_word_fifo (.*);

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // driver: host write, expected bytes go to the scoreboard queue
    task automatic host_write(input logic [31:0] d, input logic [2:0] nb);
        int k;
        logic [7:0] b;
        k = (nb >= 1 && nb <= 3) ? int'(nb) : 4;
        if (k <= DEPTH - tx_q.size()) begin
            for (int i = 0; i < k; i++) begin
                b = d[8*(tx_swap ? k-1-i : i) +: 8];
                tx_q.push_back(tx_lsb_first ? rev8(b) : b);
            end
        end
        wr_en = 1'b1; wr_data = d; wr_nbytes = nb;
        cyc();
        wr_en = 1'b0;
    endtask

    // monitor: every byte taken by the shifter is compared with the queue
    always @(negedge clk) begin
        if (rst_n && !flush && tx_valid && tx_ready && !tx_dummy) begin
            if (tx_q.size() == 0) begin
                chk(1'b0, "R2 unexpected tx byte", 32'(tx_byte), 0);
            end else begin
                logic [7:0] e;
                e = tx_q.pop_front();
                chk(tx_byte == e, "R2 R3 R4 tx byte", 32'(tx_byte), 32'(e));
            end
        end
    end

    task automatic drain();
        tx_ready = 1'b1;
        repeat (40) @(posedge clk);
        #1 tx_ready = 1'b0;
        @(negedge clk);
        chk(tx_q.size() == 0 && tx_level == 0, "R11 tx drained", 32'(tx_level), 0);
    endtask

    task automatic rx_send(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        if (rx_ready) rx_q.push_back(rx_lsb_first ? rev8(b) : b);
        cyc();
        rx_valid = 1'b0;
    endtask

    task automatic host_read(input string tag);
        int k;
        logic [31:0] e;
        k = (rx_q.size() < LANES) ? rx_q.size() : LANES;
        e = '0;
        for (int i = 0; i < k; i++) e[8*(rx_swap ? k-1-i : i) +: 8] = rx_q[i];
        rd_en = 1'b1;
        @(negedge clk);
        chk(rd_data == e, tag, rd_data, e);
        @(posedge clk);
        #1 rd_en = 1'b0;
        for (int i = 0; i < k; i++) void'(rx_q.pop_front());
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
        chk(!tx_overflow && !rx_underflow, "R1 flags", {tx_overflow, rx_underflow}, 0);
        chk(!tx_valid && rx_ready, "R1 handshake", {tx_valid, rx_ready}, 32'h1);
        cyc();

        // R2 normal order, full and partial words, R11 level
        host_write(32'h44332211, 3'd4);
        host_write(32'h88776655, 3'd0);
        host_write(32'hCCBBAA99, 3'd3);
        @(negedge clk);
        chk(tx_level == 11, "R11 tx level", 32'(tx_level), 11);
        cyc();
        // R3 reversed lanes
        tx_swap = 1'b1;
        host_write(32'h0D0C0B0A, 3'd4);
        host_write(32'hF1F2E1E2, 3'd2);
        @(negedge clk);
        chk(tx_level == 17, "R11 tx level after swap", 32'(tx_level), 17);
        cyc();
        drain();

        // R4 LSB-first transmit
        tx_swap = 1'b0; tx_lsb_first = 1'b1;
        host_write(32'h8040C001, 3'd4);
        host_write(32'h0000F00E, 3'd1);
        drain();
        tx_lsb_first = 1'b0;

        // R7 overflow: 30 bytes then a 3-byte write is refused
        for (int i = 0; i < 7; i++) host_write(32'h10101010 * (i + 1) + 32'h03020100, 3'd4);
        host_write(32'hDEADBEEF, 3'd2);
        @(negedge clk);
        chk(tx_level == 30 && !tx_overflow, "R7 before refuse", 32'(tx_level), 30);
        cyc();
        host_write(32'h55AA55AA, 3'd3);
        @(negedge clk);
        chk(tx_level == 30 && tx_overflow, "R7 refused write", {tx_overflow, tx_level}, {1'b1, 6'd30});
        cyc();
        host_write(32'h00006677, 3'd2);
        host_write(32'h12345678, 3'd1);
        @(negedge clk);
        chk(tx_level == 32 && tx_overflow, "R7 full and sticky", {tx_overflow, tx_level}, {1'b1, 6'd32});
        cyc();
        drain();

        // R9 dummy mode keeps queued data
        host_write(32'h00003C5A, 3'd2);
        tx_dummy = 1'b1; tx_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(tx_valid && tx_byte == DUMMY, "R9 dummy byte", 32'(tx_byte), 32'(DUMMY));
        end
        @(posedge clk);
        #1 tx_ready = 1'b0; tx_dummy = 1'b0;
        @(negedge clk);
        chk(tx_level == 2, "R9 fifo untouched", 32'(tx_level), 2);
        cyc();
        drain();

        // R5 receive packing, partial tail, R8 underflow
        for (int i = 1; i <= 6; i++) rx_send(8'(8'h11 * i));
        @(negedge clk);
        chk(rx_level == 6, "R11 rx level", 32'(rx_level), 6);
        cyc();
        host_read("R5 full rx word");
        host_read("R5 partial rx word");
        @(negedge clk);
        chk(rx_level == 0 && !rx_underflow, "R5 rx emptied", {rx_underflow, rx_level}, 0);
        cyc();
        host_read("R8 empty read zero");
        @(negedge clk);
        chk(rx_underflow && rx_level == 0, "R8 underflow flag", {rx_underflow, rx_level}, {1'b1, 6'd0});
        cyc();

        // R5 reversed lanes with R4 LSB-first receive
        rx_swap = 1'b1; rx_lsb_first = 1'b1;
        rx_send(8'h01); rx_send(8'h80); rx_send(8'h0F);
        host_read("R5 R4 swapped partial rx word");
        rx_swap = 1'b0; rx_lsb_first = 1'b0;

        // R6 capacity and refused byte
        for (int i = 0; i < DEPTH; i++) rx_send(8'(i * 7 + 3));
        @(negedge clk);
        chk(rx_level == 32 && !rx_ready, "R6 rx full", {rx_ready, rx_level}, {1'b0, 6'd32});
        cyc();
        rx_send(8'hEE);
        @(negedge clk);
        chk(rx_level == 32, "R6 byte refused", 32'(rx_level), 32);
        cyc();
        for (int i = 0; i < 8; i++) host_read("R6 full rx readback");

        // R10 flush beats a same-cycle write
        host_write(32'h01020304, 3'd4);
        rx_send(8'h42);
        host_write(32'hFFFFFFFF, 3'd4);
        for (int i = 0; i < 7; i++) host_write(32'h0, 3'd4);
        @(negedge clk);
        chk(tx_overflow && rx_underflow, "R10 flags set before flush", {tx_overflow, rx_underflow}, 32'h3);
        cyc();
        flush = 1'b1; wr_en = 1'b1; wr_data = 32'hA5A5A5A5; wr_nbytes = 3'd4;
        rx_valid = 1'b1; rx_byte = 8'h99;
        cyc();
        flush = 1'b0; wr_en = 1'b0; rx_valid = 1'b0;
        tx_q.delete(); rx_q.delete();
        @(negedge clk);
        chk(tx_level == 0 && rx_level == 0, "R10 levels cleared", {tx_level, rx_level}, 0);
        chk(!tx_overflow && !rx_underflow, "R10 flags cleared", {tx_overflow, rx_underflow}, 0);
        chk(!tx_valid && rd_data == 0, "R10 outputs idle", {tx_valid, rd_data[7:0]}, 0);
        cyc();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule